// File: doc/BRIEF.md
# Bus master retry limit controller

This block sits between an internal requester, such as a CPU bridge or a DMA engine, and the state machine that drives cycles onto a PCI-style bus as master. It follows one outstanding transaction at a time. It asks for the bus and tells the bus machine when to issue the cycle. When the target terminates the cycle with a retry, the block counts the retry and issues the same cycle again. The requester sees none of this.

A programmable limit bounds the retries. When the count of retries for the current transaction reaches the limit, the block gives up on the cycle. It returns a response flagged as an error, so that reads and writes both complete rather than hang, and it sets a sticky interrupt. A limit of zero removes the bound.

Top module: `retry_limit_ctl`

## Requirements
- R1: After reset, bus_req, cyc_start, rsp_valid and irq are all low.
- R2: A read accepted through req_start raises bus_req in the next cycle when not parked. cyc_start is high only in a cycle where bus_gnt or bus_park is high while the block is waiting for the bus.
- R3: A write accepted without req_wdata_vld keeps bus_req low until req_wdata_vld is seen. bus_req rises in the cycle after that.
- R4: While bus_park is high, bus_req stays low and the cycle is issued (cyc_start high) without a request.
- R5: A retry termination (term_retry) below the limit produces no response to the requester. The block returns to requesting the bus and issues the same cycle again.
- R6: With limit N>0, the N-th retry termination of a transaction aborts it. One cycle later, rsp_valid and rsp_err are high. For a read, rsp_data is the all-zero filler.
- R7: An abort sets irq in the same cycle as the error response. irq stays set until an irq_clr pulse. If an abort and irq_clr fall in the same cycle, the set wins.
- R8: A limit of zero disables aborting: any number of retries produces no response, and a later normal completion is still reported.
- R9: An aborted write still completes: rsp_valid and rsp_err are high one cycle after the aborting retry.
- R10: A limit written with cfg_we applies from the next transaction started after the write. A transaction already under way keeps its own limit.
- R11: A normal completion (term_done, which wins over term_retry) gives a one-cycle rsp_valid with rsp_err low. For a read, rsp_data equals term_rdata. The retry count restarts at zero for every transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the retry limit |
| cfg_limit | input | LW | New retry limit (0 = unlimited) |
| irq_clr | input | 1 | Write-one-to-clear pulse for the interrupt |
| req_start | input | 1 | Requester starts a transaction (taken when idle) |
| req_write | input | 1 | 1 = write, 0 = read, sampled with req_start |
| req_wdata_vld | input | 1 | First write data word is available |
| rsp_valid | output | 1 | One-cycle completion pulse to requester |
| rsp_err | output | 1 | Error flag in the completion identifier |
| rsp_data | output | DW | Read data returned with the completion |
| bus_park | input | 1 | Bus is parked on this master |
| bus_gnt | input | 1 | Arbiter grant |
| bus_req | output | 1 | Bus request |
| cyc_start | output | 1 | Issue the cycle on the bus this clock |
| term_retry | input | 1 | Target ended the cycle with a retry |
| term_done | input | 1 | Cycle completed normally |
| term_rdata | input | DW | Read data from the bus |
| irq | output | 1 | Level interrupt from the sticky abort bit |

## Verification
The retry path is driven with retry runs that stop short of the limit and end in a normal completion. It is also driven with runs that reach the limit exactly, which separates the hidden reissue from the abort by the position of the first visible response. A limit of zero is driven with a long retry run to show that the comparison is really switched off rather than wrapping. Reads and writes, parked and unparked starts, and writes whose data arrives late show when the request is raised. Changing the limit in the middle of a transaction shows which limit each transaction uses, and back-to-back transactions show that the count restarts for each one.

// File: rtl/retry_limit_ctl.sv
module retry_limit_ctl #(
  parameter int DW = 32,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [LW-1:0] cfg_limit,
  input  logic          irq_clr,
  input  logic          req_start,
  input  logic          req_write,
  input  logic          req_wdata_vld,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_data,
  input  logic          bus_park,
  input  logic          bus_gnt,
  output logic          bus_req,
  output logic          cyc_start,
  input  logic          term_retry,
  input  logic          term_done,
  input  logic [DW-1:0] term_rdata,
  output logic          irq
);
  typedef enum logic [1:0] {S_IDLE, S_WDATA, S_REQ, S_BUS} st_t;

  st_t           st;
  logic [LW-1:0] lim_reg, lim_cur, cnt;
  logic          wr;

  wire           own    = bus_gnt | bus_park;
  wire [LW-1:0]  cnt_nx = cnt + 1'b1;
  wire           retry  = (st == S_BUS) && term_retry && !term_done;
  wire           hit    = retry && (lim_cur != '0) && (cnt_nx == lim_cur);

  assign bus_req   = (st == S_REQ) && !bus_park;
  assign cyc_start = (st == S_REQ) && own;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      lim_reg   <= '0;
      lim_cur   <= '0;
      cnt       <= '0;
      wr        <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_data  <= '0;
      irq       <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (cfg_we) lim_reg <= cfg_limit;
      if (hit)          irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
      case (st)
        S_IDLE: if (req_start) begin
          cnt     <= '0;
          lim_cur <= lim_reg;
          wr      <= req_write;
          st      <= (req_write && !req_wdata_vld) ? S_WDATA : S_REQ;
        end
        S_WDATA: if (req_wdata_vld) st <= S_REQ;
        S_REQ:   if (own) st <= S_BUS;
        S_BUS: begin
          if (term_done) begin
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b0;
            rsp_data  <= wr ? '0 : term_rdata;
            cnt       <= '0;
            st        <= S_IDLE;
          end else if (hit) begin
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b1;
            rsp_data  <= '0;
            cnt       <= '0;
            st        <= S_IDLE;
          end else if (retry) begin
            cnt <= cnt_nx;
            st  <= S_REQ;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/retry_limit_chk.sv
module retry_limit_chk (
  input logic clk,
  input logic rst_n,
  input logic irq_clr,
  input logic rsp_valid,
  input logic rsp_err,
  input logic bus_park,
  input logic bus_gnt,
  input logic bus_req,
  input logic cyc_start,
  input logic irq
);
  a_r4_no_req_when_parked: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !bus_park);
  a_r2_issue_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |-> (bus_gnt || bus_park));
  a_r7_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);
  a_r6_abort_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> irq);
  a_r11_rsp_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r5_quiet_bus_on_response: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!bus_req && !cyc_start));
endmodule

bind retry_limit_ctl retry_limit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_clr(irq_clr), .rsp_valid(rsp_valid),
  .rsp_err(rsp_err), .bus_park(bus_park), .bus_gnt(bus_gnt),
  .bus_req(bus_req), .cyc_start(cyc_start), .irq(irq)
);

// File: tb/sim_retry_limit_ctl.sv
`timescale 1ns/1ps
module sim_retry_limit_ctl;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, irq_clr = 0, req_start = 0, req_write = 0, req_wdata_vld = 0;
  logic bus_park = 0, bus_gnt = 0, term_retry = 0, term_done = 0;
  logic [7:0]  cfg_limit = 0;
  logic [31:0] term_rdata = 0;
  logic        rsp_valid, rsp_err, bus_req, cyc_start, irq;
  logic [31:0] rsp_data;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  retry_limit_ctl u0 (.*);

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic tick; @(negedge clk); endtask

  task automatic set_limit(int n);
    cfg_limit = n[7:0]; cfg_we = 1; tick; cfg_we = 0;
  endtask

  task automatic start(bit w, bit vld);
    req_write = w; req_wdata_vld = vld; req_start = 1; tick; req_start = 0;
  endtask

  task automatic issue(string r);
    if (bus_park) begin
      chk({r, " bus_req parked"}, bus_req, 0);
      chk({r, " cyc_start parked"}, cyc_start, 1);
      tick;
    end else begin
      chk({r, " bus_req"}, bus_req, 1);
      chk({r, " cyc_start before grant"}, cyc_start, 0);
      bus_gnt = 1; #1;
      chk({r, " cyc_start on grant"}, cyc_start, 1);
      tick; bus_gnt = 0;
    end
  endtask

  task automatic retry_hidden(string r);
    term_retry = 1; tick; term_retry = 0;
    chk({r, " no rsp on retry"}, rsp_valid, 0);
    issue({r, " reissue"});
  endtask

  task automatic retry_abort(string r);
    term_retry = 1; tick; term_retry = 0;
    chk({r, " abort rsp_valid"}, rsp_valid, 1);
    chk({r, " abort rsp_err"}, rsp_err, 1);
  endtask

  task automatic finish_ok(string r, logic [31:0] d, bit w);
    term_rdata = d; term_done = 1; tick; term_done = 0;
    chk({r, " rsp_valid"}, rsp_valid, 1);
    chk({r, " rsp_err"}, rsp_err, 0);
    if (!w) chk({r, " rsp_data"}, rsp_data, d);
    tick;
    chk({r, " rsp pulse ends"}, rsp_valid, 0);
  endtask

  task automatic t_reset;
    chk("R1 bus_req", bus_req, 0);
    chk("R1 cyc_start", cyc_start, 0);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_read_ok;
    set_limit(3);
    start(0, 0);
    issue("R2");
    retry_hidden("R5");
    finish_ok("R11 read", 32'hCAFE_0001, 0);
  endtask

  task automatic t_read_abort;
    start(0, 0);
    issue("R6");
    retry_hidden("R6 first");
    retry_hidden("R6 second");
    retry_abort("R6");
    chk("R6 filler data", rsp_data, 0);
    chk("R7 irq on abort", irq, 1);
    tick; tick;
    chk("R7 irq sticky", irq, 1);
    irq_clr = 1; tick; irq_clr = 0;
    chk("R7 irq cleared", irq, 0);
  endtask

  task automatic t_write;
    start(1, 0);
    tick; tick;
    chk("R3 no req before data", bus_req, 0);
    req_wdata_vld = 1; tick; req_wdata_vld = 0;
    issue("R3");
    finish_ok("R3 write", 0, 1);
    bus_park = 1;
    start(1, 1);
    issue("R4");
    finish_ok("R4 parked write", 0, 1);
    bus_park = 0;
    set_limit(1);
    start(1, 1);
    issue("R9");
    retry_abort("R9 write");
    chk("R9 irq", irq, 1);
    irq_clr = 1; tick; irq_clr = 0;
  endtask

  task automatic t_unlimited;
    set_limit(0);
    start(0, 0);
    issue("R8");
    for (int i = 0; i < 300; i++) retry_hidden("R8");
    chk("R8 irq stays low", irq, 0);
    finish_ok("R8 completes", 32'h1234_5678, 0);
  endtask

  task automatic t_limit_change;
    set_limit(2);
    start(0, 0);
    issue("R10");
    set_limit(1);
    retry_hidden("R10 old limit kept");
    retry_abort("R10 old limit");
    irq_clr = 1; tick; irq_clr = 0;
    start(0, 0);
    issue("R10 new");
    retry_abort("R10 new limit");
    irq_clr = 1; tick; irq_clr = 0;
    chk("R7 irq clear", irq, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick; tick;
    t_reset;
    rst_n = 1; tick;
    t_reset;
    t_read_ok;
    t_read_abort;
    t_write;
    t_unlimited;
    t_limit_change;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule